// File: doc/BRIEF.md
# Leaky Sync Integrator Field Detector

This block finds field synchronisation in a stream of 8-bit composite video samples, working the way an RC integrator does in an analogue receiver. Each sample is compared with a programmable slice level. A sample at or below the level counts as sync-low and adds one unit of charge to a counter. Any other sample drains one unit, and the counter never drops below zero.

A short line sync pulse adds only a few tens of units, and the rest of the line drains that charge away. A run of broad pulses in the vertical interval adds charge much faster than it drains. When the charge reaches a programmable trip level, the block raises a one-clock field strobe and clears the counter. Spurious low samples from tape dropouts or impulse noise add little charge and do not trip it.

The counter value is also brought out on a port so the trip margin can be watched.

Top module: `field_sync_integrator`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `charge` is 0 and `field_strobe` is 0.
- R2: A sync-low sample (`sample` <= `slice_level`) for which `charge`+1 stays below `trip_level` makes `charge` one higher on the next clock.
- R3: A sample above `slice_level` while `charge` is non-zero makes `charge` one lower on the next clock.
- R4: A sample above `slice_level` while `charge` is 0 leaves `charge` at 0.
- R5: A sync-low sample for which `charge`+1 >= `trip_level`, taken while `field_strobe` is low, sets `field_strobe` to 1 on the next clock, and `charge` reads 0 in that same clock.
- R6: `field_strobe` is never high on two consecutive clocks. A sync-low sample taken in a strobe clock only adds charge, as in R2.
- R7: The slice boundary is inclusive. A sample equal to `slice_level` counts as sync-low, and `slice_level`+1 does not.
- R8: With a slice level of 30 and a trip level of 1800, lines of 864 clocks that carry a 64-sample sync pulse never trip. A train of eight half-line broad pulses, each 400 samples low and 32 samples high, trips exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample | input | 8 | Video sample, one per clock |
| slice_level | input | 8 | Highest value treated as sync-low |
| trip_level | input | 12 | Charge at which a field sync is flagged |
| field_strobe | output | 1 | One-clock field-sync flag |
| charge | output | 12 | Current integrator value |

## Verification
All state in this block sits in the charge counter and the strobe register, and both are visible at the ports. A wrong increment, a missed floor or a bad clear shows on `charge` in the very next clock. A trip decision made against the wrong value shows as a strobe that is early, late or missing, one clock after the sample that should have decided it. Comparing both outputs every clock against an independent model therefore catches a fault within one sample period. Long video-like patterns also check that small per-clock errors do not add up into a missed or extra field strobe.

// File: rtl/field_sync_integrator.sv
module field_sync_integrator #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] slice_level,
  input  logic [ACC_W-1:0]    trip_level,
  output logic                field_strobe,
  output logic [ACC_W-1:0]    charge
);

  localparam logic [ACC_W-1:0] FULL = '1;
  localparam logic [ACC_W:0]   ONE  = (ACC_W+1)'(1);

  logic             sync_low;
  logic [ACC_W:0]   raised;
  logic [ACC_W-1:0] up_val;
  logic [ACC_W-1:0] down_val;
  logic             fire;

  assign sync_low = (sample <= slice_level);
  assign raised   = {1'b0, charge} + ONE;
  assign up_val   = (charge == FULL) ? FULL : raised[ACC_W-1:0];
  assign down_val = (charge == '0) ? '0 : charge - 1'b1;
  assign fire     = sync_low && !field_strobe && (raised >= {1'b0, trip_level});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      charge       <= '0;
      field_strobe <= 1'b0;
    end else begin
      field_strobe <= fire;
      charge       <= fire ? '0 : (sync_low ? up_val : down_val);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (charge == '0) && !field_strobe);

  assert_charge_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sample <= slice_level) && (({1'b0, charge} + ONE) < {1'b0, trip_level}))
    |=> (charge == $past(charge) + 1'b1));

  assert_charge_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sample > slice_level) && (charge != '0)) |=> (charge == $past(charge) - 1'b1));

  assert_floor_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sample > slice_level) && (charge == '0)) |=> (charge == '0));

  assert_trip_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sample <= slice_level) && !field_strobe &&
     (({1'b0, charge} + ONE) >= {1'b0, trip_level})) |=> field_strobe);

  assert_strobe_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    field_strobe |-> (charge == '0));

  assert_single_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    field_strobe |=> !field_strobe);

endmodule

// File: tb/field_sync_integrator_test.sv
module field_sync_integrator_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sample = 8'd100;
  logic [7:0]  slice_level = 8'd30;
  logic [11:0] trip_level = 12'd1800;
  logic        field_strobe;
  logic [11:0] charge;

  int checks = 0;
  int fails = 0;
  int m_charge = 0;
  int m_strobe = 0;
  int strobe_count = 0;
  string m_tag = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_sync_integrator uut (
    .clk(clk), .rst_n(rst_n), .sample(sample), .slice_level(slice_level),
    .trip_level(trip_level), .field_strobe(field_strobe), .charge(charge)
  );

  task automatic compare(input string seg);
    checks++;
    if (int'(charge) != m_charge || int'(field_strobe) != m_strobe) begin
      fails++;
      $display("FAIL %s/%s charge=%0d strobe=%0d expected charge=%0d strobe=%0d",
               seg, m_tag, charge, field_strobe, m_charge, m_strobe);
    end
  endtask

  // behavioural reference of R2..R7
  task automatic step(input int smp, input string seg);
    bit low;
    bit trip;
    sample = 8'(smp);
    @(posedge clk);
    low  = (smp <= int'(slice_level));
    trip = low && (m_strobe == 0) && (m_charge + 1 >= int'(trip_level));
    if (trip) begin
      m_charge = 0; m_strobe = 1; m_tag = "R5";
    end else begin
      m_strobe = 0;
      if (low) begin
        m_charge = (m_charge < 4095) ? m_charge + 1 : 4095; m_tag = "R2";
      end else if (m_charge > 0) begin
        m_charge--; m_tag = "R3";
      end else m_tag = "R4";
    end
    @(negedge clk);
    if (field_strobe) strobe_count++;
    compare(seg);
  endtask

  task automatic count_check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s strobe count got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      m_tag = "R1"; compare("R1");
    end
    rst_n = 1'b1;
    step(100, "R1");

    // R2 then R3 then R4: ramp up, drain, sit at floor
    for (int i = 0; i < 20; i++) step(0, "R2");
    for (int i = 0; i < 25; i++) step(200, "R3_R4");

    // R7: boundary of the slice comparison
    slice_level = 8'd30;
    for (int i = 0; i < 6; i++) step(30, "R7");
    for (int i = 0; i < 6; i++) step(31, "R7");
    slice_level = 8'd60;
    for (int i = 0; i < 4; i++) step(60, "R7");
    for (int i = 0; i < 10; i++) step(61, "R7");
    slice_level = 8'd30;

    // R5 and R6: tiny trip level, continuous sync
    trip_level = 12'd1;
    for (int i = 0; i < 12; i++) step(0, "R6");
    trip_level = 12'd5;
    for (int i = 0; i < 20; i++) step(0, "R5");
    trip_level = 12'd0;
    for (int i = 0; i < 6; i++) step(0, "R6");
    for (int i = 0; i < 4; i++) step(200, "R6");

    // R8: normal lines never trip
    trip_level = 12'd1800;
    strobe_count = 0;
    for (int ln = 0; ln < 20; ln++)
      for (int i = 0; i < 864; i++) step(i < 64 ? 0 : 100, "R8");
    count_check("R8 lines", strobe_count, 0);

    // R8: eight broad pulses trip once
    strobe_count = 0;
    for (int p = 0; p < 8; p++)
      for (int i = 0; i < 432; i++) step(i < 400 ? 0 : 100, "R8");
    for (int i = 0; i < 864; i++) step(100, "R8");
    count_check("R8 broad", strobe_count, 1);

    // noise splats on picture lines stay quiet
    strobe_count = 0;
    for (int ln = 0; ln < 4; ln++)
      for (int i = 0; i < 864; i++) step((i < 64 || i % 97 == 5) ? 3 : 150, "R8");
    count_check("R8 noise", strobe_count, 0);

    // R1: reset mid-charge
    for (int i = 0; i < 30; i++) step(0, "R2");
    @(negedge clk);
    rst_n = 1'b0;
    m_charge = 0; m_strobe = 0; m_tag = "R1";
    #1 compare("R1");
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step(0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule